// File: doc/BRIEF.md
# Shadow-Checked Accumulator Register

This block is a wide accumulator register that can tell when its own input arrived too late. Each storage bit has two flip-flops. The main flop captures on the system clock. A shadow flop captures on a second clock that runs a fixed, short delay behind the main one. When the next-state value settles before the main edge, both copies agree. When it settles after the main edge but before the delayed edge, the two copies disagree. The block then raises an error, discards the wrong main value and puts the shadow value in its place.

The delayed clock is generated outside the block and arrives as an input. The clear and load-enable controls are sampled on the main clock only. The shadow flops take the data input on the delayed edge. In the cycle after a correction the block asserts an error pulse and a stall flag, and a saturating counter records how many corrections have happened. A load offered at the edge that performs a correction is not taken, so the upstream stage has to offer that value again.

Top module: `razor_acc`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `q`, `err_pulse`, `stall` and `err_cnt` are all zero.
- R2: At a main-clock edge where `ld_en` is 1, `clr` is 0 and the two copies agree, `q` takes the value `d_in` had at that edge.
- R3: At a main-clock edge where `ld_en`, `clr` and the copy mismatch are all 0, `q` keeps its value.
- R4: At a main-clock edge with `clr` = 1, `q` and `err_cnt` go to zero and `err_pulse` stays 0, even if a mismatch is pending at that edge.
- R5: Suppose a load whose data changes between the main edge and the delayed edge leaves the copies different. Then `err_pulse` is 1 for the cycle after the next main edge. In every other case it is 0.
- R6: At the edge that follows such a mismatch, `q` takes the value the shadow flops captured, which is `d_in` as it stood at the delayed edge.
- R7: A load presented at a correcting edge is ignored: after that edge `q` holds the shadow value, not the newly offered `d_in`.
- R8: `stall` is 1 exactly in the cycles where `err_pulse` is 1.
- R9: `err_cnt` rises by one at each correcting edge and stays at its all-ones value (16 bits by default) once it gets there.
- R10: A load whose data is stable around both clock edges never raises `err_pulse`.
- R11: Detection is per bit and conservative. A late change of any single bit, including bit 0 and bit 39, is flagged and corrected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| clk_dly | input | 1 | Delayed copy of the main clock, used by the shadow flops |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| clr | input | 1 | Synchronous clear of the value and the error counter |
| ld_en | input | 1 | Load enable |
| d_in | input | 40 | Next accumulator value |
| q | output | 40 | Accumulator value |
| err_pulse | output | 1 | One-cycle flag after a correction |
| stall | output | 1 | Tells the upstream stage that its last load was discarded |
| err_cnt | output | 16 | Saturating count of corrections |

## Verification
A correction and a synchronous clear can land on the same main edge, and clear must win. To provoke this, the bench makes a load late on purpose and then asserts `clr` on the very next cycle. It expects zero value, zero count and no pulse. A correction can also coincide with a fresh load. The bench offers new data at the correcting edge and judges the result by whether `q` shows the shadow value rather than the new data. The late arrival itself is produced by changing `d_in` one nanosecond after the main edge and before the delayed edge.

// File: rtl/racc_pkg.sv
package racc_pkg;

  parameter int unsigned RACC_WIDTH_DEF = 40;
  parameter int unsigned RACC_CNT_DEF   = 16;

  // next-state source selected for the main register
  typedef enum logic [1:0] {
    SEL_HOLD  = 2'd0,
    SEL_LOAD  = 2'd1,
    SEL_CLEAR = 2'd2,
    SEL_FIX   = 2'd3
  } nxt_sel_e;

endpackage

// File: rtl/racc_rst_sync.sv
module racc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nxt;
  end

  assign rst_s = chain_q[STAGES-1];

endmodule

// File: rtl/racc_bit.sv
module racc_bit (
  input  logic clk,
  input  logic clk_dly,
  input  logic rst_n,
  input  logic m_en,
  input  logic m_d,
  input  logic s_en,
  input  logic s_d,
  output logic m_q,
  output logic s_q,
  output logic mis
);

  logic m_nxt;
  logic s_nxt;

  always_comb begin
    m_nxt = m_en ? m_d : m_q;
    s_nxt = s_en ? s_d : s_q;
  end

  // main copy, system clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_q <= 1'b0;
    else        m_q <= m_nxt;
  end

  // shadow copy, delayed clock (edge-triggered, not a latch)
  always_ff @(posedge clk_dly or negedge rst_n) begin
    if (!rst_n) s_q <= 1'b0;
    else        s_q <= s_nxt;
  end

  assign mis = m_q ^ s_q;

endmodule

// File: rtl/racc_err_ctrl.sv
module racc_err_ctrl #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             mism,
  output logic             err_pulse,
  output logic             stall,
  output logic [CNT_W-1:0] err_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             fix;
  logic             pulse_nxt;
  logic             stall_nxt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;

  always_comb begin
    fix       = mism & ~clr;
    pulse_nxt = fix;
    stall_nxt = fix;
    cnt_en    = clr | (fix & (err_cnt != CNT_MAX));
    if (clr) cnt_nxt = '0;
    else     cnt_nxt = err_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pulse <= 1'b0;
      stall     <= 1'b0;
      err_cnt   <= '0;
    end else begin
      err_pulse <= pulse_nxt;
      stall     <= stall_nxt;
      if (cnt_en) err_cnt <= cnt_nxt;
    end
  end

  // R5: a mismatch that is not cleared produces the pulse
  p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mism && !clr) |=> err_pulse);
  // R5 / R4: no pulse without an uncleared mismatch
  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mism || clr) |=> !err_pulse);
  // R9: one step per correction below the ceiling
  p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mism && !clr && err_cnt != CNT_MAX) |=> err_cnt == $past(err_cnt) + 1'b1);
  // R9: ceiling holds
  p_cnt_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt == CNT_MAX && !clr) |=> err_cnt == CNT_MAX);
  // R4: clear empties the counter
  p_cnt_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> err_cnt == '0);

endmodule

// File: rtl/razor_acc.sv
module razor_acc
  import racc_pkg::*;
#(
  parameter int unsigned W     = RACC_WIDTH_DEF,
  parameter int unsigned CNT_W = RACC_CNT_DEF
) (
  input  logic             clk,
  input  logic             clk_dly,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ld_en,
  input  logic [W-1:0]     d_in,
  output logic [W-1:0]     q,
  output logic             err_pulse,
  output logic             stall,
  output logic [CNT_W-1:0] err_cnt
);

  logic         rst_s;
  logic [W-1:0] q_main;
  logic [W-1:0] q_shd;
  logic [W-1:0] mis_bit;
  logic         mism;
  nxt_sel_e     sel;
  nxt_sel_e     cap_sel_q;
  logic [W-1:0] main_nxt;
  logic [W-1:0] shd_nxt;
  logic         main_en;
  logic         shd_en;

  racc_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  // any differing bit counts: conservative detection
  assign mism = |mis_bit;

  always_comb begin
    if (clr)        sel = SEL_CLEAR;
    else if (mism)  sel = SEL_FIX;
    else if (ld_en) sel = SEL_LOAD;
    else            sel = SEL_HOLD;
  end

  always_comb begin
    main_en = (sel != SEL_HOLD);
    case (sel)
      SEL_CLEAR: main_nxt = '0;
      SEL_FIX:   main_nxt = q_shd;
      SEL_LOAD:  main_nxt = d_in;
      default:   main_nxt = q_main;
    endcase
  end

  // control for the shadow copy is taken at the main edge
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) cap_sel_q <= SEL_HOLD;
    else        cap_sel_q <= sel;
  end

  always_comb begin
    shd_en  = (cap_sel_q == SEL_LOAD) || (cap_sel_q == SEL_CLEAR);
    shd_nxt = (cap_sel_q == SEL_CLEAR) ? '0 : d_in;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    racc_bit u_bit (
      .clk     (clk),
      .clk_dly (clk_dly),
      .rst_n   (rst_s),
      .m_en    (main_en),
      .m_d     (main_nxt[i]),
      .s_en    (shd_en),
      .s_d     (shd_nxt[i]),
      .m_q     (q_main[i]),
      .s_q     (q_shd[i]),
      .mis     (mis_bit[i])
    );
  end

  racc_err_ctrl #(.CNT_W(CNT_W)) u_err (
    .clk       (clk),
    .rst_n     (rst_s),
    .clr       (clr),
    .mism      (mism),
    .err_pulse (err_pulse),
    .stall     (stall),
    .err_cnt   (err_cnt)
  );

  assign q = q_main;

  // R2: timely load lands in the main copy
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (ld_en && !clr && !mism) |=> q == $past(d_in));
  // R3: idle edge keeps the value
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_s)
    (!ld_en && !clr && !mism) |=> $stable(q));
  // R4: clear wins over everything
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_s)
    clr |=> (q == '0) && !err_pulse);
  // R6 / R7 / R8: correction restores the shadow value and stalls
  p_fix_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (mism && !clr) |=> (q == $past(q_shd)) && stall);

endmodule

// File: tb/sim_razor_acc.sv
module sim_razor_acc;

  localparam int W     = 40;
  localparam int CNT_W = 4;

  logic             clk;
  logic             clk_dly;
  logic             rst_n;
  logic             clr;
  logic             ld_en;
  logic [W-1:0]     d_in;
  logic [W-1:0]     q;
  logic             err_pulse;
  logic             stall;
  logic [CNT_W-1:0] err_cnt;

  int n_chk;
  int n_err;
  bit done;

  // model state
  logic [W-1:0]     m_q;
  logic [W-1:0]     m_shd;
  logic             m_pend;
  logic             m_err;
  logic [CNT_W-1:0] m_cnt;

  razor_acc #(.W(W), .CNT_W(CNT_W)) u0 (
    .clk       (clk),
    .clk_dly   (clk_dly),
    .rst_n     (rst_n),
    .clr       (clr),
    .ld_en     (ld_en),
    .d_in      (d_in),
    .q         (q),
    .err_pulse (err_pulse),
    .stall     (stall),
    .err_cnt   (err_cnt)
  );

  // 125 MHz main clock, delayed clock 2 ns behind
  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end
  initial begin
    clk_dly = 1'b0;
    #2;
    forever #4 clk_dly = ~clk_dly;
  end

  function automatic logic [W-1:0] rnd40();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (c == {CNT_W{1'b1}}) ? c : c + 1'b1;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one main-clock cycle, entered and left at a falling edge
  task automatic cyc(input logic ld, input logic cl, input logic [W-1:0] good,
                     input logic late, input logic [W-1:0] stale);
    string qtag;
    ld_en = ld;
    clr   = cl;
    d_in  = (late && ld) ? stale : good;
    @(posedge clk);
    if (late && ld) begin
      #1;
      d_in = good;
    end
    @(negedge clk);
    // model of the edge just passed
    if (cl) begin
      m_q = '0; m_cnt = '0; m_err = 1'b0; m_pend = 1'b0; qtag = "R4";
    end else if (m_pend) begin
      m_q = m_shd; m_err = 1'b1; m_cnt = sat_inc(m_cnt); m_pend = 1'b0;
      qtag = ld ? "R7" : "R6";
    end else begin
      m_err = 1'b0;
      if (ld) begin
        m_q    = late ? stale : good;
        m_shd  = good;
        m_pend = late && (stale != good);
        qtag   = "R2";
      end else begin
        qtag = "R3";
      end
    end
    chk(qtag, 64'(q), 64'(m_q));
    chk("R5", 64'(err_pulse), 64'(m_err));
    chk("R8", 64'(stall), 64'(m_err));
    chk("R9", 64'(err_cnt), 64'(m_cnt));
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a;
    logic [W-1:0] b;
    n_chk = 0; n_err = 0; done = 1'b0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; clr = 1'b0; ld_en = 1'b0; d_in = '0;
    m_q = '0; m_shd = '0; m_pend = 1'b0; m_err = 1'b0; m_cnt = '0;
    repeat (3) @(negedge clk);
    // R1: values during reset
    chk("R1", 64'(q), 64'd0);
    chk("R1", 64'(err_pulse), 64'd0);
    chk("R1", 64'(stall), 64'd0);
    chk("R1", 64'(err_cnt), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", 64'(q), 64'd0);

    // R2 / R10: timely load, no error
    a = 40'h12_3456_789A;
    cyc(1'b1, 1'b0, a, 1'b0, '0);
    cyc(1'b0, 1'b0, '0, 1'b0, '0);
    chk("R10", 64'(err_pulse), 64'd0);
    // R3: hold several cycles with changing input
    d_in = rnd40();
    cyc(1'b0, 1'b0, rnd40(), 1'b0, '0);
    chk("R3", 64'(q), 64'(a));

    // R5 / R6: late load, main sees stale data
    b = 40'hA5_A5A5_0F0F;
    cyc(1'b1, 1'b0, b, 1'b1, 40'h00_0000_1111);
    cyc(1'b0, 1'b0, '0, 1'b0, '0);
    chk("R6", 64'(q), 64'(b));

    // R7: load offered at the correcting edge is discarded
    a = 40'hFF_0000_FFFF;
    cyc(1'b1, 1'b0, a, 1'b1, 40'h0F_0000_FFFF);
    cyc(1'b1, 1'b0, 40'h33_3333_3333, 1'b0, '0);
    chk("R7", 64'(q), 64'(a));
    cyc(1'b1, 1'b0, 40'h33_3333_3333, 1'b0, '0);

    // R11: single-bit late changes at both ends
    cyc(1'b1, 1'b0, 40'h80_0000_0000, 1'b1, 40'h00_0000_0000);
    cyc(1'b0, 1'b0, '0, 1'b0, '0);
    chk("R11", 64'(err_pulse), 64'd1);
    cyc(1'b1, 1'b0, 40'h00_0000_0001, 1'b1, 40'h00_0000_0000);
    cyc(1'b0, 1'b0, '0, 1'b0, '0);
    chk("R11", 64'(q), 64'd1);

    // R4: clear coinciding with a pending correction
    cyc(1'b1, 1'b0, 40'h55_5555_5555, 1'b1, 40'h54_5555_5555);
    cyc(1'b0, 1'b1, '0, 1'b0, '0);
    chk("R4", 64'(err_cnt), 64'd0);
    chk("R4", 64'(err_pulse), 64'd0);

    // R9: drive the counter into saturation
    for (int i = 0; i < 20; i++) begin
      a = rnd40();
      cyc(1'b1, 1'b0, a, 1'b1, ~a);
      cyc(1'b0, 1'b0, '0, 1'b0, '0);
    end
    chk("R9", 64'(err_cnt), 64'(16'h000F));
    cyc(1'b0, 1'b1, '0, 1'b0, '0);

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic ld;
      logic cl;
      logic lt;
      logic [W-1:0] g;
      logic [W-1:0] s;
      ld = ($urandom_range(0, 3) != 0);
      cl = ($urandom_range(0, 15) == 0);
      lt = ($urandom_range(0, 3) == 0);
      g  = rnd40();
      s  = ($urandom_range(0, 1) == 0) ? (g ^ (40'd1 << $urandom_range(0, W - 1))) : rnd40();
      cyc(ld, cl, g, lt, s);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule